// File: doc/BRIEF.md
# Tagged Operand Wakeup Scheduler

This block is a small pool of scheduling slots that sits in front of one pipelined execution unit. An operation is accepted into the lowest-numbered free slot. Each source operand is given either as a ready value, with producer tag zero, or as the nonzero tag of whatever will compute it. A slot that is still missing an operand listens to a shared result broadcast, which carries a valid flag, a tag and a data word. When it sees its producer's tag, it takes the data. Once a slot holds both values it competes for the execution unit, and the lowest-numbered ready slot wins. The unit is a fixed-latency stub. Its result is sent out with the slot's own tag, and that slot becomes free again.

The surrounding logic owns the shared broadcast. It feeds this block's own results back into the snoop input, and other producers may use the bus in cycles when this block is not broadcasting. Slot tags run from 1 to the slot count. Other producers on the bus must use tags above that range.

Top module: `rs_sched`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `iss_tag` is 1 and `res_valid` is 0.
- R2: An operation is accepted only when a slot is free. With all slots busy, `iss_ready` is 0 and an asserted `iss_valid` has no effect: no result is ever produced for it.
- R3: Slot i (counting from 0) carries tag i+1. `iss_tag` shows the tag of the lowest-numbered free slot, and an accepted operation takes that slot.
- R4: A source whose producer tag is 0 takes its value from the issue port. A nonzero producer tag makes the slot wait for that producer.
- R5: A waiting slot copies `cdb_data` into each missing operand whose producer tag equals `cdb_tag` while `cdb_valid` is 1. Its own results, fed back, wake dependent slots.
- R6: A broadcast whose tag matches a source in the same cycle that the operation is accepted supplies that source directly.
- R7: A slot is dispatched only when both operands are present. At most one slot is dispatched per cycle, and the lowest-numbered ready slot goes first.
- R8: The result appears on `res_valid` exactly LATENCY cycles after dispatch. An operation whose operands are both ready at issue shows its result LATENCY+1 cycles after the issue edge.
- R9: Operation codes are 0 = add (j+k), 1 = subtract (j-k), 2 = bitwise AND and 3 = bitwise XOR. All results are taken modulo 2^16.
- R10: A result is broadcast with the producing slot's tag, one result per cycle at most. The slot stays busy through its broadcast cycle and is free from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered for acceptance |
| iss_op | input | 2 | Operation code (R9) |
| iss_qj | input | 3 | Producer tag of first source, 0 = value given |
| iss_vj | input | 16 | First source value |
| iss_qk | input | 3 | Producer tag of second source, 0 = value given |
| iss_vk | input | 16 | Second source value |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | 3 | Tag the next accepted operation will receive |
| cdb_valid | input | 1 | Shared broadcast valid |
| cdb_tag | input | 3 | Shared broadcast producer tag |
| cdb_data | input | 16 | Shared broadcast data |
| res_valid | output | 1 | This block's result is valid |
| res_tag | output | 3 | Tag of the slot producing the result |
| res_data | output | 16 | Result word |

## Verification
A capture from the broadcast lands in the slot at the edge that samples it. The slot is dispatched one cycle later, and its result is visible LATENCY edges after that. A fully ready issue therefore produces its result at the third falling-edge sample after the issue edge, and a slot freed by a broadcast is reusable from the next sample on. The reference model steps on each rising edge, and all comparisons happen on the falling edge, so these latencies are checked cycle for cycle. The directed checks also test the exact sample at which the first result appears and the order in which simultaneously woken slots finish.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DATA_W = 16;
    localparam int NUM_RS = 4;
    localparam int TAG_W  = $clog2(NUM_RS + 1);
    localparam int IDX_W  = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } op_e;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t data;
    } bcast_t;

    typedef struct packed {
        logic  rdy;
        tag_t  src;
        word_t val;
    } opnd_t;

    typedef struct packed {
        logic  busy;
        logic  fired;
        op_e   op;
        opnd_t j;
        opnd_t k;
    } slot_t;

    // Fill one source at issue time, taking a same-cycle broadcast if it matches.
    function automatic opnd_t take_src(tag_t q, word_t v, bcast_t b);
        opnd_t o;
        o.src = q;
        if (q == '0) begin
            o.rdy = 1'b1;
            o.val = v;
        end else if (b.valid && b.tag == q) begin
            o.rdy = 1'b1;
            o.val = b.data;
        end else begin
            o.rdy = 1'b0;
            o.val = '0;
        end
        return o;
    endfunction

    function automatic word_t alu(op_e op, word_t a, word_t b);
        word_t r;
        unique case (op)
            OP_ADD: r = a + b;
            OP_SUB: r = a - b;
            OP_AND: r = a & b;
            OP_XOR: r = a ^ b;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rs_lowest.sv
module rs_lowest
    import rs_pkg::*;
#(
    parameter int N = NUM_RS
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign found = |req;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  slot_t  load_val,
    input  bcast_t bus,
    input  logic   fire,
    input  logic   retire,
    output slot_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else begin
            if (fire)
                q.fired <= 1'b1;
            if (retire) begin
                q.busy  <= 1'b0;
                q.fired <= 1'b0;
            end
            if (q.busy && !q.j.rdy && bus.valid && bus.tag == q.j.src) begin
                q.j.val <= bus.data;
                q.j.rdy <= 1'b1;
            end
            if (q.busy && !q.k.rdy && bus.valid && bus.tag == q.k.src) begin
                q.k.val <= bus.data;
                q.k.rdy <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_fu.sv
module rs_fu
    import rs_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  bcast_t in_res,
    output bcast_t out_res
);
    bcast_t stg [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LATENCY; i++) stg[i] <= '0;
        end else begin
            stg[0] <= in_res;
            for (int i = 1; i < LATENCY; i++) stg[i] <= stg[i-1];
        end
    end

    assign out_res = stg[LATENCY-1];
endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_vk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    slot_t             slots [NUM_RS];
    logic [NUM_RS-1:0] busy_vec;
    logic [NUM_RS-1:0] rdy_vec;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  disp_idx;
    logic              disp_valid;
    bcast_t            bus;
    bcast_t            fu_in;
    bcast_t            fu_out;
    slot_t             new_slot;

    assign bus = '{valid: cdb_valid, tag: cdb_tag, data: cdb_data};

    always_comb begin
        new_slot.busy  = 1'b1;
        new_slot.fired = 1'b0;
        new_slot.op    = op_e'(iss_op);
        new_slot.j     = take_src(iss_qj, iss_vj, bus);
        new_slot.k     = take_src(iss_qk, iss_vk, bus);
    end

    rs_lowest #(.N(NUM_RS)) u_alloc (
        .req   (~busy_vec),
        .found (iss_ready),
        .idx   (free_idx)
    );

    rs_lowest #(.N(NUM_RS)) u_pick (
        .req   (rdy_vec),
        .found (disp_valid),
        .idx   (disp_idx)
    );

    assign iss_tag = tag_t'(free_idx) + tag_t'(1);

    for (genvar g = 0; g < NUM_RS; g++) begin : g_slot
        rs_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (iss_valid && iss_ready && free_idx == IDX_W'(g)),
            .load_val (new_slot),
            .bus      (bus),
            .fire     (disp_valid && disp_idx == IDX_W'(g)),
            .retire   (fu_out.valid && fu_out.tag == tag_t'(g + 1)),
            .q        (slots[g])
        );
        assign busy_vec[g] = slots[g].busy;
        assign rdy_vec[g]  = slots[g].busy && !slots[g].fired &&
                             slots[g].j.rdy && slots[g].k.rdy;
    end

    always_comb begin
        fu_in.valid = disp_valid;
        fu_in.tag   = tag_t'(disp_idx) + tag_t'(1);
        fu_in.data  = alu(slots[disp_idx].op, slots[disp_idx].j.val,
                          slots[disp_idx].k.val);
    end

    rs_fu #(.LATENCY(LATENCY)) u_fu (
        .clk     (clk),
        .rst     (rst),
        .in_res  (fu_in),
        .out_res (fu_out)
    );

    assign res_valid = fu_out.valid;
    assign res_tag   = fu_out.tag;
    assign res_data  = fu_out.data;
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk
    import rs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_tag,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [NUM_RS-1:0] busy_vec,
    input logic              disp_valid,
    input logic [IDX_W-1:0]  disp_idx,
    input logic [IDX_W-1:0]  free_idx
);
    logic [IDX_W-1:0] res_idx;
    assign res_idx = IDX_W'(res_tag - TAG_W'(1));

    // R3: advertised tag is a valid slot tag
    a_r3_tag_range: assert property (@(posedge clk) disable iff (rst)
        iss_ready |-> (iss_tag != '0 && iss_tag <= TAG_W'(NUM_RS)));

    // R2: accepted operation occupies the advertised slot
    a_r2_issue_claims: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> busy_vec[$past(free_idx)]);

    // R7: only an occupied slot is dispatched
    a_r7_dispatch_busy: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> busy_vec[disp_idx]);

    // R10: producer still holds its slot while broadcasting
    a_r10_owner_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tag != '0 && busy_vec[res_idx]));

    // R10: producer slot free right after its broadcast
    a_r10_freed: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !busy_vec[$past(res_idx)]);
endmodule

bind rs_sched rs_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_tag    (iss_tag),
    .res_valid  (res_valid),
    .res_tag    (res_tag),
    .busy_vec   (busy_vec),
    .disp_valid (disp_valid),
    .disp_idx   (disp_idx),
    .free_idx   (free_idx)
);

// File: tb/rs_sched_test.sv
module rs_sched_test;
    localparam int LAT = 2;
    localparam int N   = rs_pkg::NUM_RS;

    logic        clk = 0;
    logic        rst = 1;
    logic        iss_valid = 0;
    logic [1:0]  iss_op = 0;
    logic [2:0]  iss_qj = 0, iss_qk = 0;
    logic [15:0] iss_vj = 0, iss_vk = 0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        ext_v = 0;
    logic [2:0]  ext_t = 0;
    logic [15:0] ext_d = 0;
    logic        cdb_valid;
    logic [2:0]  cdb_tag;
    logic [15:0] cdb_data;
    logic        res_valid;
    logic [2:0]  res_tag;
    logic [15:0] res_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int cap_t[$];
    int cap_d[$];

    always #5 clk = ~clk;

    assign cdb_valid = res_valid | ext_v;
    assign cdb_tag   = res_valid ? res_tag  : ext_t;
    assign cdb_data  = res_valid ? res_data : ext_d;

    rs_sched #(.LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    // Behavioural reference model
    int m_busy[N], m_fired[N], m_op[N];
    int m_vj[N], m_vk[N], m_qj[N], m_qk[N], m_rj[N], m_rk[N];
    int m_pv[LAT], m_pt[LAT], m_pd[LAT];

    function automatic int calc(int op, int a, int b);
        case (op)
            0: return (a + b) & 16'hFFFF;
            1: return (a - b) & 16'hFFFF;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_busy[i] = 0; m_fired[i] = 0;
            end
            for (int s = 0; s < LAT; s++) m_pv[s] = 0;
        end else begin
            int bv, bt, bd, d, f, orv, ort;
            orv = m_pv[LAT-1]; ort = m_pt[LAT-1];
            bv = orv | int'(ext_v);
            bt = orv ? ort : int'(ext_t);
            bd = orv ? m_pd[LAT-1] : int'(ext_d);
            d = -1; f = -1;
            for (int i = 0; i < N; i++) begin
                if (d < 0 && m_busy[i] && !m_fired[i] && m_rj[i] && m_rk[i]) d = i;
                if (f < 0 && !m_busy[i]) f = i;
            end
            for (int s = LAT - 1; s > 0; s--) begin
                m_pv[s] = m_pv[s-1]; m_pt[s] = m_pt[s-1]; m_pd[s] = m_pd[s-1];
            end
            m_pv[0] = (d >= 0);
            m_pt[0] = d + 1;
            m_pd[0] = (d >= 0) ? calc(m_op[d], m_vj[d], m_vk[d]) : 0;
            if (d >= 0) m_fired[d] = 1;
            if (orv) begin m_busy[ort-1] = 0; m_fired[ort-1] = 0; end
            for (int i = 0; i < N; i++) begin
                if (m_busy[i] && bv) begin
                    if (!m_rj[i] && m_qj[i] == bt) begin m_vj[i] = bd; m_rj[i] = 1; end
                    if (!m_rk[i] && m_qk[i] == bt) begin m_vk[i] = bd; m_rk[i] = 1; end
                end
            end
            if (iss_valid && f >= 0) begin
                m_busy[f] = 1; m_fired[f] = 0; m_op[f] = iss_op;
                m_qj[f] = iss_qj; m_qk[f] = iss_qk;
                m_rj[f] = (iss_qj == 0) || (bv && bt == iss_qj);
                m_rk[f] = (iss_qk == 0) || (bv && bt == iss_qk);
                m_vj[f] = (iss_qj == 0) ? iss_vj : (m_rj[f] ? bd : 0);
                m_vk[f] = (iss_qk == 0) ? iss_vk : (m_rk[f] ? bd : 0);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 5000) begin
            chk(0, "watchdog expired", cyc, 0);
            finish_run();
        end
    end

    task automatic tick();
        int mr, mt;
        @(negedge clk);
        mr = 0; mt = 0;
        for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) begin mr = 1; mt = i + 1; end
        chk(iss_ready == mr, "R2 iss_ready vs model", iss_ready, mr);
        if (mr) chk(iss_tag == mt, "R3 iss_tag vs model", iss_tag, mt);
        chk(res_valid == m_pv[LAT-1], "R8 res_valid vs model", res_valid, m_pv[LAT-1]);
        if (m_pv[LAT-1]) begin
            chk(res_tag == m_pt[LAT-1], "R10 res_tag vs model", res_tag, m_pt[LAT-1]);
            chk(res_data == m_pd[LAT-1], "R9 res_data vs model", res_data, m_pd[LAT-1]);
        end
        if (res_valid) begin cap_t.push_back(res_tag); cap_d.push_back(res_data); end
    endtask

    task automatic do_issue(input int op, input int vj, input int qj, input int vk, input int qk);
        iss_valid = 1; iss_op = op[1:0];
        iss_vj = vj[15:0]; iss_qj = qj[2:0]; iss_vk = vk[15:0]; iss_qk = qk[2:0];
        tick();
        iss_valid = 0;
    endtask

    task automatic inject(input int t, input int d);
        ext_v = 1; ext_t = t[2:0]; ext_d = d[15:0];
        tick();
        ext_v = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(iss_ready == 1, "R1 iss_ready after reset", iss_ready, 1);
        chk(iss_tag == 1, "R1 iss_tag after reset", iss_tag, 1);
        chk(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
        rst = 0;

        // R4 / R8 / R9: both values ready at issue
        do_issue(0, 5, 0, 7, 0);
        tick();
        chk(res_valid == 0, "R8 no result before LATENCY+1", res_valid, 0);
        tick();
        chk(res_valid == 1, "R8 result at LATENCY+1", res_valid, 1);
        chk(res_tag == 1 && res_data == 12, "R9 add result", res_data, 12);
        tick();

        // R5 / R7: waiting entry overtaken by a ready one
        cap_t.delete(); cap_d.delete();
        chk(iss_tag == 1, "R3 freed slot reused", iss_tag, 1);
        do_issue(1, 0, 5, 3, 0);
        do_issue(3, 16'hF0F0, 0, 16'h00FF, 0);
        idle(6);
        chk(cap_t.size() == 1, "R7 waiting slot not dispatched", cap_t.size(), 1);
        if (cap_t.size() > 0)
            chk(cap_t[0] == 2 && cap_d[0] == 16'hF00F, "R9 xor result", cap_d[0], 16'hF00F);
        inject(5, 10);
        idle(6);
        chk(cap_t.size() == 2, "R5 woken slot completes", cap_t.size(), 2);
        if (cap_t.size() > 1)
            chk(cap_t[1] == 1 && cap_d[1] == 7, "R5 captured operand used", cap_d[1], 7);

        // R6: broadcast during the issue cycle
        cap_t.delete(); cap_d.delete();
        ext_v = 1; ext_t = 6; ext_d = 100;
        do_issue(0, 0, 6, 1, 0);
        ext_v = 0;
        idle(6);
        chk(cap_t.size() == 1, "R6 same-cycle capture completes", cap_t.size(), 1);
        if (cap_t.size() > 0)
            chk(cap_d[0] == 101, "R6 same-cycle value", cap_d[0], 101);

        // R2 / R3 / R7: fill all slots, simultaneous wakeup
        cap_t.delete(); cap_d.delete();
        for (int i = 0; i < N; i++) begin
            int ops[4] = '{0, 1, 2, 3};
            int vks[4] = '{1, 2, 16'h0F, 16'hFF};
            chk(iss_tag == i + 1, "R3 allocation order", iss_tag, i + 1);
            do_issue(ops[i], 0, 7, vks[i], 0);
        end
        chk(iss_ready == 0, "R2 full pool not ready", iss_ready, 0);
        do_issue(0, 16'h1234, 0, 0, 0);
        do_issue(0, 16'h1234, 0, 0, 0);
        inject(7, 50);
        idle(8);
        chk(cap_t.size() == 4, "R2 ignored issue gives no result", cap_t.size(), 4);
        if (cap_t.size() == 4) begin
            int et[4] = '{1, 2, 3, 4};
            int ed[4] = '{51, 48, 2, 16'hCD};
            for (int i = 0; i < 4; i++) begin
                chk(cap_t[i] == et[i], "R7 lowest index first", cap_t[i], et[i]);
                chk(cap_d[i] == ed[i], "R9 op results", cap_d[i], ed[i]);
            end
        end

        // R5 / R10: dependence on own result
        cap_t.delete(); cap_d.delete();
        do_issue(0, 2, 0, 3, 0);
        do_issue(0, 0, 1, 10, 0);
        idle(8);
        chk(cap_t.size() == 2, "R5 chain count", cap_t.size(), 2);
        if (cap_t.size() == 2)
            chk(cap_t[1] == 2 && cap_d[1] == 15, "R5 own-result wakeup", cap_d[1], 15);
        chk(iss_ready == 1 && iss_tag == 1, "R10 slots freed", iss_tag, 1);

        finish_run();
    end
endmodule